// File: doc/BRIEF.md
# Error Pin Controller with Key-Protected Release

This block drives an active-low error pin that leaves the chip. A vector of error channels feeds it; each channel has an enable bit that decides whether its errors may pull the pin low, and a sticky status flag that records any error on that channel. When an enabled channel reports an error, the pin goes low and a low-time counter is loaded from a programmable reload register. The counter then counts down one step per clock and stops at zero.

Software releases the pin by writing a release key to the key register. The pin goes high only once the counter has reached zero. A release key written early stays pending until then. A second key puts the pin into a diagnostic forcing mode that holds it low. Any other key written in that mode returns the block to normal operation. The forcing request is refused while a detected error holds the pin low.

Two resets exist. Power-on reset clears everything and drives the pin high. Warm reset clears the registers and the state machine but leaves the pin at its current level. A pin still low after a warm reset cannot be released with the release key. It can be released by entering forcing mode and then leaving it.

Top module: `errpin_ctrl`

## Requirements
- R1: When `err_in` has a bit set whose enable bit (address 0, bit i for channel i) is 1, `err_pin_n` is 0 after the next rising clock edge. In the same edge the low-time counter loads the reload value.
- R2: An error on any channel sets that channel's status flag (address 1, bit i), whether or not the channel is enabled. An error on a disabled channel leaves `err_pin_n` unchanged.
- R3: Writing to address 1 clears each status flag whose `wdata` bit is 1. Clearing flags does not release `err_pin_n`.
- R4: After an error, write key 0x5 to address 3 bits [3:0]. Take the error edge as E0, the key write sampled at edge E0+w, and a reload value of r. `err_pin_n` goes high after edge E0+max(r+1, w) and stays low before that.
- R5: A new enabled error while the pin is low reloads the counter and cancels a pending 0x5 request. A fresh 0x5 write is then needed.
- R6: Key 0xA written while no error holds the pin enters forcing mode, and `err_pin_n` is 0 after that edge. Key 0xA written while a detected error holds the pin is ignored. A later key other than 0x5 does not release the pin.
- R7: In forcing mode, writing 0xA again keeps the pin low. Any other key value returns the block to normal mode, with `err_pin_n` high after that edge.
- R8: While `por_n` is 0, `err_pin_n` goes high on the next edge. All registers return to their defaults: enable 0, flags 0, key 0, reload 16.
- R9: While `warm_rst_n` is 0, `err_pin_n` keeps its level and registers return to their defaults. If the pin is still low afterwards, 0x5 writes have no effect. Writing 0xA and then any non-0xA key releases it.
- R10: The reload register (address 2, bits [LT_W-1:0]) defaults to 16. The counter holds at zero once reached, so a late 0x5 releases on the edge that samples it.
- R11: Reads are combinational. Address 0 returns the enable mask. Address 1 returns the flags in bits [NUM_CH-1:0] and the pin level in bit 31. Address 2 returns the reload value. Address 3 returns the last written key in bits [3:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| warm_rst_n | input | 1 | Warm reset, active low, synchronous; pin keeps its level |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 enable, 1 status, 2 reload, 3 key) |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr` |
| err_in | input | NUM_CH | Error request per channel, sampled each clock |
| err_pin_n | output | 1 | Active-low error pin |

## Verification
The release path is driven with random reload values, random enable masks and random key-write delays. This separates a release timed by the counter from one timed by the write, and covers a reload of zero. Directed sequences cover the cases the random loop cannot reach. A key 0xA written during a detected error must not let a later 0x0 write release the pin. A pending release must be cancelled by a second error. A disabled channel must set its flag without touching the pin. A warm reset must leave the pin low and make 0x5 useless, while the 0xA-then-other route still releases it. A power-on reset must bring the pin high.

// File: rtl/errpin_pkg.sv
package errpin_pkg;
  localparam logic [3:0] KEY_RELEASE = 4'h5;
  localparam logic [3:0] KEY_FORCE   = 4'hA;
  localparam int         KEY_W       = 4;

  typedef enum logic [1:0] {
    ADDR_ENABLE = 2'd0,
    ADDR_STATUS = 2'd1,
    ADDR_LTIME  = 2'd2,
    ADDR_KEY    = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_ERR   = 2'd1,
    PS_FORCE = 2'd2
  } pin_state_e;
endpackage

// File: rtl/errpin_regs.sv
module errpin_regs
  import errpin_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int LT_W       = 16,
  parameter int LT_DEFAULT = 16,
  parameter int DW         = 32
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DW-1:0]     wdata,
  input  logic [NUM_CH-1:0] err_in,
  input  logic              pin_level,
  output logic [DW-1:0]     rdata,
  output logic [NUM_CH-1:0] en_mask,
  output logic [LT_W-1:0]   lt_reload,
  output logic              key_wr,
  output logic [KEY_W-1:0]  key_val
);
  localparam int PIN_BIT = DW - 1;

  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] flags_q;
  logic [LT_W-1:0]   lt_q;
  logic [KEY_W-1:0]  key_q;
  logic              any_rst;
  logic              sts_wr;
  logic [NUM_CH-1:0] clr_mask;
  logic              unused_wdata;

  // new flags: errors set, write-one clears, a set in the same cycle wins
  function automatic logic [NUM_CH-1:0] flag_next(input logic [NUM_CH-1:0] cur,
                                                  input logic [NUM_CH-1:0] set,
                                                  input logic [NUM_CH-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  assign any_rst      = !por_n || !warm_rst_n;
  assign sts_wr       = wr_en && (addr == ADDR_STATUS);
  assign clr_mask     = sts_wr ? wdata[NUM_CH-1:0] : '0;
  assign key_wr       = wr_en && (addr == ADDR_KEY);
  assign key_val      = wdata[KEY_W-1:0];
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk) begin
    if (any_rst) begin
      en_q    <= '0;
      flags_q <= '0;
      lt_q    <= LT_W'(LT_DEFAULT);
      key_q   <= '0;
    end else begin
      flags_q <= flag_next(flags_q, err_in, clr_mask);
      if (wr_en && addr == ADDR_ENABLE) en_q  <= wdata[NUM_CH-1:0];
      if (wr_en && addr == ADDR_LTIME)  lt_q  <= wdata[LT_W-1:0];
      if (key_wr)                       key_q <= key_val;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_ENABLE: rdata[NUM_CH-1:0] = en_q;
      ADDR_STATUS: begin
        rdata[NUM_CH-1:0] = flags_q;
        rdata[PIN_BIT]    = pin_level;
      end
      ADDR_LTIME:  rdata[LT_W-1:0]  = lt_q;
      default:     rdata[KEY_W-1:0] = key_q;
    endcase
  end

  assign en_mask   = en_q;
  assign lt_reload = lt_q;

  // R2: every channel error leaves its flag set
  a_r2_flag_set: assert property (@(posedge clk) disable iff (any_rst)
    (|err_in) |=> ((flags_q & $past(err_in)) == $past(err_in)));

  // R3: written ones clear flags unless an error re-sets them
  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (any_rst)
    sts_wr |=> ((flags_q & $past(clr_mask & ~err_in)) == '0));

  // R10: reload register only changes through its own address
  a_r10_reload_stable: assert property (@(posedge clk) disable iff (any_rst)
    !(wr_en && addr == ADDR_LTIME) |=> $stable(lt_q));
endmodule

// File: rtl/errpin_timer.sv
module errpin_timer #(
  parameter int LT_W = 16
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            warm_rst_n,
  input  logic            load,
  input  logic [LT_W-1:0] reload,
  output logic            cnt_zero
);
  logic [LT_W-1:0] cnt_q;
  logic            any_rst;

  // one countdown step that saturates at zero
  function automatic logic [LT_W-1:0] count_step(input logic [LT_W-1:0] cur);
    return (cur == '0) ? cur : cur - LT_W'(1);
  endfunction

  assign any_rst = !por_n || !warm_rst_n;

  always_ff @(posedge clk) begin
    if (any_rst)   cnt_q <= '0;
    else if (load) cnt_q <= reload;
    else           cnt_q <= count_step(cnt_q);
  end

  assign cnt_zero = (cnt_q == '0);

  // R5: each error event reloads the counter
  a_r5_reload: assert property (@(posedge clk) disable iff (any_rst)
    load |=> (cnt_q == $past(reload)));

  // R10: counter holds at zero
  a_r10_hold_zero: assert property (@(posedge clk) disable iff (any_rst)
    (!load && cnt_zero) |=> cnt_zero);

  // R4: counter steps down by one while running
  a_r4_step: assert property (@(posedge clk) disable iff (any_rst)
    (!load && !cnt_zero) |=> (cnt_q == $past(cnt_q) - LT_W'(1)));
endmodule

// File: rtl/errpin_fsm.sv
module errpin_fsm
  import errpin_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             warm_rst_n,
  input  logic             err_hit,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_val,
  input  logic             cnt_zero,
  output logic             load,
  output logic             pin_n
);
  pin_state_e st_q, st_d;
  logic       pin_q, pin_d;
  logic       pend_q, pend_d;
  logic       any_rst;
  logic       err_evt;
  logic       key_rel_wr;
  logic       force_ok;
  logic       force_exit;
  logic       rel_ok;

  assign any_rst    = !por_n || !warm_rst_n;
  assign err_evt    = err_hit && (st_q != PS_FORCE);
  assign key_rel_wr = key_wr && (key_val == KEY_RELEASE);
  assign force_ok   = key_wr && (key_val == KEY_FORCE) && (st_q == PS_IDLE) && !err_hit;
  assign force_exit = key_wr && (key_val != KEY_FORCE) && (st_q == PS_FORCE);
  assign rel_ok     = (st_q == PS_ERR) && !err_hit && cnt_zero && (pend_q || key_rel_wr);

  always_comb begin
    st_d   = st_q;
    pin_d  = pin_q;
    pend_d = pend_q;
    case (st_q)
      PS_IDLE: begin
        if (err_evt) begin
          st_d   = PS_ERR;
          pin_d  = 1'b0;
          pend_d = 1'b0;
        end else if (force_ok) begin
          st_d  = PS_FORCE;
          pin_d = 1'b0;
        end
      end
      PS_ERR: begin
        if (err_evt) begin
          pend_d = 1'b0;
        end else if (rel_ok) begin
          st_d   = PS_IDLE;
          pin_d  = 1'b1;
          pend_d = 1'b0;
        end else if (key_rel_wr) begin
          pend_d = 1'b1;
        end
      end
      PS_FORCE: begin
        if (force_exit) begin
          st_d  = PS_IDLE;
          pin_d = 1'b1;
        end
      end
      default: begin
        st_d   = PS_IDLE;
        pend_d = 1'b0;
      end
    endcase
  end

  // state and pending request: both resets
  always_ff @(posedge clk) begin
    if (any_rst) begin
      st_q   <= PS_IDLE;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
    end
  end

  // pin level: power-on reset only, warm reset freezes it
  always_ff @(posedge clk) begin
    if (!por_n)          pin_q <= 1'b1;
    else if (warm_rst_n) pin_q <= pin_d;
  end

  assign load  = err_evt;
  assign pin_n = pin_q;

  // R1: enabled error outside forcing mode pulls the pin low
  a_r1_err_low: assert property (@(posedge clk) disable iff (any_rst)
    (err_hit && st_q != PS_FORCE) |=> !pin_q);

  // R4: no release while the counter is still running
  a_r4_no_early_release: assert property (@(posedge clk) disable iff (any_rst)
    (st_q == PS_ERR && !cnt_zero) |=> !pin_q);

  // R6: forcing request refused while an error holds the pin
  a_r6_force_blocked: assert property (@(posedge clk) disable iff (any_rst)
    (st_q == PS_ERR && key_wr && key_val == KEY_FORCE) |=> (st_q != PS_FORCE));

  // R7: forcing mode keeps the pin low
  a_r7_force_low: assert property (@(posedge clk) disable iff (any_rst)
    (st_q == PS_FORCE) |-> !pin_q);

  // R9: warm reset leaves the pin level alone
  a_r9_warm_keeps_pin: assert property (@(posedge clk) disable iff (!por_n)
    !warm_rst_n |=> (pin_q == $past(pin_q)));
endmodule

// File: rtl/errpin_ctrl.sv
module errpin_ctrl
  import errpin_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int LT_W       = 16,
  parameter int LT_DEFAULT = 16,
  parameter int DW         = 32
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [NUM_CH-1:0] err_in,
  output logic              err_pin_n
);
  logic [NUM_CH-1:0] en_mask;
  logic [LT_W-1:0]   lt_reload;
  logic              key_wr;
  logic [KEY_W-1:0]  key_val;
  logic              err_hit;
  logic              load;
  logic              cnt_zero;
  logic              pin_n;

  assign err_hit   = |(err_in & en_mask);
  assign err_pin_n = pin_n;

  errpin_regs #(
    .NUM_CH(NUM_CH), .LT_W(LT_W), .LT_DEFAULT(LT_DEFAULT), .DW(DW)
  ) i_regs (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .err_in(err_in),
    .pin_level(pin_n), .rdata(rdata), .en_mask(en_mask),
    .lt_reload(lt_reload), .key_wr(key_wr), .key_val(key_val)
  );

  errpin_timer #(.LT_W(LT_W)) i_timer (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n),
    .load(load), .reload(lt_reload), .cnt_zero(cnt_zero)
  );

  errpin_fsm i_fsm (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n),
    .err_hit(err_hit), .key_wr(key_wr), .key_val(key_val),
    .cnt_zero(cnt_zero), .load(load), .pin_n(pin_n)
  );

  // R8: power-on reset drives the pin high
  a_r8_por_high: assert property (@(posedge clk)
    !por_n |=> err_pin_n);
endmodule

// File: tb/test_errpin_ctrl.sv
module test_errpin_ctrl;
  localparam int NUM_CH = 8;
  localparam int LT_W   = 16;
  localparam int DW     = 32;

  logic              clk = 1'b0;
  logic              por_n = 1'b0;
  logic              warm_rst_n = 1'b1;
  logic              wr_en = 1'b0;
  logic [1:0]        addr = 2'd0;
  logic [DW-1:0]     wdata = '0;
  logic [DW-1:0]     rdata;
  logic [NUM_CH-1:0] err_in = '0;
  logic              err_pin_n;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  errpin_ctrl #(.NUM_CH(NUM_CH), .LT_W(LT_W), .LT_DEFAULT(16), .DW(DW)) i_errpin_ctrl (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .err_in(err_in),
    .err_pin_n(err_pin_n)
  );

  // edge on which the pin goes high: reload r, key write w edges after the error
  function automatic int rel_edge(input int r, input int w);
    return (r + 1 > w) ? r + 1 : w;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick();
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse_err(input logic [NUM_CH-1:0] m);
    err_in = m;
    tick();
    err_in = '0;
  endtask

  // after an error edge: write 0x5 at edge w, return first edge with pin high
  task automatic measure(input int w, output int m_high);
    m_high = -1;
    for (int m = 1; m <= 40; m++) begin
      if (m == w) wr(2'd3, 32'h5);
      else tick();
      if (err_pin_n === 1'b1) begin
        m_high = m;
        break;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    int mh;
    void'($urandom(32'h1234_5EED));
    @(negedge clk);
    tick();
    por_n = 1'b1;
    tick();

    // R8 / R11 reset state
    check("R8 pin after por", {31'd0, err_pin_n}, 32'd1);
    rd(2'd0, d); check("R8 enable default", d, 32'd0);
    rd(2'd1, d); check("R11 status pin bit", d, 32'h8000_0000);
    rd(2'd2, d); check("R10 reload default", d, 32'd16);
    rd(2'd3, d); check("R8 key default", d, 32'd0);

    // R2 disabled channel
    pulse_err(8'h04);
    check("R2 disabled pin", {31'd0, err_pin_n}, 32'd1);
    rd(2'd1, d); check("R2 flag on disabled", d, 32'h8000_0004);
    wr(2'd1, 32'h4);
    rd(2'd1, d); check("R3 w1c", d, 32'h8000_0000);

    // R1 / R3 / R6 / R4 directed
    wr(2'd0, 32'hFF);
    wr(2'd2, 32'd3);
    pulse_err(8'h02);
    check("R1 pin low", {31'd0, err_pin_n}, 32'd0);
    rd(2'd1, d); check("R1 flag set", d, 32'h0000_0002);
    wr(2'd1, 32'h2);
    rd(2'd1, d); check("R3 clear keeps pin low", d, 32'h0000_0000);
    wr(2'd3, 32'hA);
    check("R6 force ignored", {31'd0, err_pin_n}, 32'd0);
    wr(2'd3, 32'h0);
    check("R6 no release after ignored force", {31'd0, err_pin_n}, 32'd0);
    wr(2'd3, 32'h5);
    check("R4 release", {31'd0, err_pin_n}, 32'd1);
    rd(2'd3, d); check("R11 key readback", d, 32'd5);

    // R5 pending cancelled by a new error
    wr(2'd2, 32'd4);
    pulse_err(8'h01);
    tick();
    wr(2'd3, 32'h5);
    pulse_err(8'h01);
    repeat (10) tick();
    check("R5 pending cancelled", {31'd0, err_pin_n}, 32'd0);
    wr(2'd3, 32'h5);
    check("R5 fresh key releases", {31'd0, err_pin_n}, 32'd1);
    wr(2'd1, 32'hFF);

    // R6 / R7 forcing mode
    wr(2'd3, 32'hA);
    check("R6 force low", {31'd0, err_pin_n}, 32'd0);
    rd(2'd1, d); check("R11 status in force", d, 32'h0);
    wr(2'd3, 32'hA);
    check("R7 force stays", {31'd0, err_pin_n}, 32'd0);
    wr(2'd3, 32'h3);
    check("R7 force exit", {31'd0, err_pin_n}, 32'd1);

    // R9 warm reset
    wr(2'd2, 32'd2);
    pulse_err(8'h01);
    warm_rst_n = 1'b0;
    tick();
    warm_rst_n = 1'b1;
    check("R9 pin kept low", {31'd0, err_pin_n}, 32'd0);
    rd(2'd0, d); check("R9 enable cleared", d, 32'd0);
    rd(2'd1, d); check("R9 status cleared", d, 32'd0);
    rd(2'd2, d); check("R9 reload default", d, 32'd16);
    wr(2'd3, 32'h5);
    repeat (20) tick();
    wr(2'd3, 32'h5);
    check("R9 release key ignored", {31'd0, err_pin_n}, 32'd0);
    wr(2'd3, 32'hA);
    check("R9 force entered", {31'd0, err_pin_n}, 32'd0);
    wr(2'd3, 32'h0);
    check("R9 force route releases", {31'd0, err_pin_n}, 32'd1);

    // R10 default reload timing
    wr(2'd0, 32'hFF);
    pulse_err(8'h80);
    measure(1, mh);
    check("R10 default reload release edge", mh, rel_edge(16, 1));

    // R8 power-on reset while low
    pulse_err(8'h10);
    por_n = 1'b0;
    tick();
    por_n = 1'b1;
    check("R8 por releases pin", {31'd0, err_pin_n}, 32'd1);
    rd(2'd1, d); check("R8 flags cleared", d, 32'h8000_0000);

    // R4 / R10 random release timing
    for (int it = 0; it < 40; it++) begin
      int r;
      int w;
      int ch;
      logic [NUM_CH-1:0] en;
      r  = $urandom_range(0, 6);
      w  = $urandom_range(1, 9);
      ch = $urandom_range(0, NUM_CH - 1);
      en = NUM_CH'($urandom) | (NUM_CH'(1) << ch);
      wr(2'd2, DW'(r));
      wr(2'd0, DW'(en));
      pulse_err(NUM_CH'(1) << ch);
      check("R1 random pin low", {31'd0, err_pin_n}, 32'd0);
      measure(w, mh);
      check("R4 random release edge", mh, rel_edge(r, w));
      wr(2'd1, 32'hFF);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule